// File: doc/BRIEF.md
# Infrared Pulse-Width Symbol Receiver

This block watches a demodulated infrared line and turns it into a stream of raw timing symbols. Each symbol is two measured lengths: the active (pulse) phase, and the inactive (space) phase that follows it. Both are counted in measurement units of ten prescaled ticks. With the prescale value set to the input clock rate in MHz minus one, a tick is 1 µs and a unit is 10 µs. Finished symbols go into a FIFO. Software reads the FIFO through a small word-addressed register bus. The receiver does no protocol decoding; a software decoder interprets the stored timings.

Software turns the block on, waits for the busy flag to drop, and writes the setup word. That word holds the maximum symbol width, the line polarity, the FIFO interrupt level, the raw-capture enable and the prescale value. A write to the arm register then starts capture. An interrupt can be raised for three events: the FIFO reaching the programmed level, an end-of-frame timeout, and a symbol lost to a full FIFO. On overflow the FIFO is not flushed. Software drains the FIFO itself, then clears the flag.

Top module: `ir_symbol_rx`

## Requirements
- R1: After reset, status reads 0, the FIFO count reads 0, busy reads 0, the mask register reads 0x7, irq is low, and the setup word reads 0x3E800080.
- R2: Writing 1 in bit 0 to the enable register (0x00) makes the busy register (0x1C) read 1 for BUSY_CYCLES clocks, and no symbol is captured during that time.
- R3: A symbol is stored as one 32-bit entry. Bits [15:0] hold the pulse length and bits [31:16] the space length, counted in whole units of 10*(prescale+1) clocks. The pulse phase starts when the line becomes active (low, with format bit 14 clear). The space phase runs until the line becomes active again.
- R4: The setup word (0x04) holds the maximum width in bits [31:16]. If pulse plus space reaches this width during a space, the symbol is stored with space = maximum width − pulse, the timeout status bit 9 is set, and the receiver waits for the next pulse.
- R5: The count register (0x20) returns the number of stored entries. Each read of the data register (0x24) returns the oldest entry and removes it. A read of the data register while the FIFO is empty returns 0 and changes nothing.
- R6: Status bit 8 (received) is set when a store leaves at least level+1 entries in the FIFO, where level is setup bits [13:8].
- R7: A symbol that completes while the FIFO is full is dropped and sets status bit 10. The FIFO keeps its stored entries, and its count stays at the depth until software reads them out.
- R8: Writing to the clear register (0x30) with bit 16, 17 or 18 set clears status bit 8, 9 or 10 respectively. Other bits of the written word have no effect.
- R9: Mask register (0x28) bits [2:0] block the received, timeout and overflow conditions. Status bits [26:24] report the raw bits [10:8] with blocked conditions removed, and irq is high when any of bits [26:24] is set.
- R10: Capture runs only when the block is enabled, not busy, armed by any write to the arm register (0x34), and raw-capture setup bit 7 is set. Line activity before arming stores nothing.
- R11: With setup bit 14 set, the line polarity is inverted: a high level is the pulse phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (a data-register read pops the FIFO) |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid during busRd |
| irIn | input | 1 | Demodulated infrared line, asynchronous |
| irq | output | 1 | Interrupt request, OR of the unmasked status bits |

## Verification
Three kinds of bursts are sent.
- A symbol followed by a long idle line separates a normal space, which ends at the next pulse, from a space cut off by the maximum-width rule. The cut-off value must equal the width minus the pulse.
- Bursts of two and three symbols, under an interrupt level of three entries, show whether the received flag follows the programmed threshold rather than each single store.
- A burst run with the polarity inverted checks that the phases swap with the setup bit.

A separate train of 65 short symbols against a 64-entry FIFO shows that overflow drops new symbols and keeps the old ones. Read-out order and the clear, mask and arming rules are checked between bursts.

// File: rtl/irrx_pkg.sv
package irrx_pkg;

  localparam int DUR_W = 16;
  localparam int WORD_W = 32;

  localparam logic [7:0] ADDR_ON     = 8'h00;
  localparam logic [7:0] ADDR_SETUP  = 8'h04;
  localparam logic [7:0] ADDR_BUSY   = 8'h1C;
  localparam logic [7:0] ADDR_FILL   = 8'h20;
  localparam logic [7:0] ADDR_DATA   = 8'h24;
  localparam logic [7:0] ADDR_MASK   = 8'h28;
  localparam logic [7:0] ADDR_STATUS = 8'h2C;
  localparam logic [7:0] ADDR_CLEAR  = 8'h30;
  localparam logic [7:0] ADDR_ARM    = 8'h34;

  // control -> datapath strobes and settings
  typedef struct packed {
    logic             run;
    logic             invert;
    logic [6:0]       prescale;
    logic [DUR_W-1:0] maxWidth;
    logic             popReq;
  } ctrlStrobe_t;

  // datapath -> control events
  typedef struct packed {
    logic symDone;
    logic symTimeout;
    logic symDropped;
  } dpEvent_t;

endpackage

// File: rtl/irrx_fifo.sv
module irrx_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic             full,
  output logic [CNT_W-1:0] fill,
  output logic [WIDTH-1:0] head
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  logic doPush, doPop;
  assign full   = (fill == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && (fill != '0);
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      fill <= fill + 1'b1;
      else if (doPop && !doPush) fill <= fill - 1'b1;
    end
  end

endmodule

// File: rtl/irrx_datapath.sv
module irrx_datapath
  import irrx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int UNIT_DIV = 10,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int UW = $clog2(UNIT_DIV + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       ctl,
  input  logic              irIn,
  output dpEvent_t          evt,
  output logic [CNT_W-1:0]  fill,
  output logic [WORD_W-1:0] head
);

  typedef enum logic [1:0] {ST_IDLE, ST_PULSE, ST_SPACE} measState_t;

  logic [SYNC_STAGES-1:0] syncQ;
  logic active;
  measState_t state;
  logic [6:0] usCnt;
  logic [UW-1:0] unitCnt;
  logic usTick, unitTick;
  logic [DUR_W-1:0] pulseCnt, spaceCnt;
  logic [DUR_W:0] sumNext;
  logic widthHit, symDone, fifoFull;
  logic [WORD_W-1:0] symWord;

  // input synchronizer, idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], irIn};
  end

  assign active   = ~(syncQ[SYNC_STAGES-1] ^ ctl.invert);
  assign usTick   = (usCnt == ctl.prescale);
  assign unitTick = usTick && (unitCnt == UW'(UNIT_DIV - 1));
  assign sumNext  = {1'b0, pulseCnt} + {1'b0, spaceCnt} + {{DUR_W{1'b0}}, 1'b1};
  assign widthHit = unitTick && (sumNext >= {1'b0, ctl.maxWidth});

  assign symDone = ctl.run && (state == ST_SPACE) && (active || widthHit);
  assign symWord = active ? {spaceCnt, pulseCnt} : {sumNext[DUR_W-1:0] - pulseCnt, pulseCnt};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      usCnt    <= '0;
      unitCnt  <= '0;
      pulseCnt <= '0;
      spaceCnt <= '0;
    end else if (!ctl.run) begin
      state    <= ST_IDLE;
      usCnt    <= '0;
      unitCnt  <= '0;
      pulseCnt <= '0;
      spaceCnt <= '0;
    end else begin
      usCnt <= usTick ? '0 : usCnt + 1'b1;
      if (usTick) unitCnt <= unitTick ? '0 : unitCnt + 1'b1;
      case (state)
        ST_IDLE: begin
          if (active) begin
            state    <= ST_PULSE;
            pulseCnt <= '0;
            spaceCnt <= '0;
            usCnt    <= '0;
            unitCnt  <= '0;
          end
        end
        ST_PULSE: begin
          if (!active) state <= ST_SPACE;
          else if (unitTick && pulseCnt < ctl.maxWidth) pulseCnt <= pulseCnt + 1'b1;
        end
        ST_SPACE: begin
          if (active) begin
            state    <= ST_PULSE;
            pulseCnt <= '0;
            spaceCnt <= '0;
            usCnt    <= '0;
            unitCnt  <= '0;
          end else if (widthHit) begin
            state <= ST_IDLE;
          end else if (unitTick) begin
            spaceCnt <= spaceCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  irrx_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
    .clk   (clk),
    .rstN  (rstN),
    .push  (symDone),
    .pop   (ctl.popReq),
    .wdata (symWord),
    .full  (fifoFull),
    .fill  (fill),
    .head  (head)
  );

  assign evt.symDone    = symDone && !fifoFull;
  assign evt.symTimeout = symDone && !active;
  assign evt.symDropped = symDone && fifoFull;

endmodule

// File: rtl/irrx_ctrl.sv
module irrx_ctrl
  import irrx_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int BUSY_CYCLES = 8,
  localparam int BW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busAddr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  input  dpEvent_t          evt,
  input  logic [CNT_W-1:0]  fill,
  input  logic [WORD_W-1:0] head,
  output ctrlStrobe_t       ctl,
  output logic              irq
);

  logic enReg, armed, rawMode;
  logic [BW-1:0] busyCnt;
  logic [DUR_W-1:0] maxWidth;
  logic [1:0] fmt;
  logic [5:0] level;
  logic [6:0] prescale;
  logic [2:0] maskReg, rawStat, setStat, clrStat, shownStat;
  logic [CNT_W:0] afterStore;
  logic levelHit, isWrite;

  assign isWrite = busWr;

  assign afterStore = {1'b0, fill} + (CNT_W+1)'(1) - (CNT_W+1)'(ctl.popReq);
  assign levelHit   = evt.symDone && (int'(afterStore) > int'(level));
  assign setStat    = {evt.symDropped, evt.symTimeout, levelHit};
  assign clrStat    = (isWrite && busAddr == ADDR_CLEAR) ? busWdata[18:16] : 3'b000;
  assign shownStat  = rawStat & ~maskReg;
  assign irq        = |shownStat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      armed    <= 1'b0;
      busyCnt  <= '0;
      maxWidth <= 16'h3E80;
      fmt      <= 2'b00;
      level    <= '0;
      rawMode  <= 1'b1;
      prescale <= '0;
      maskReg  <= 3'b111;
      rawStat  <= '0;
    end else begin
      if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
      rawStat <= (rawStat & ~clrStat) | setStat;
      if (isWrite) begin
        case (busAddr)
          ADDR_ON: begin
            enReg <= busWdata[0];
            if (busWdata[0]) busyCnt <= BW'(BUSY_CYCLES);
            else begin
              armed   <= 1'b0;
              busyCnt <= '0;
            end
          end
          ADDR_SETUP: begin
            maxWidth <= busWdata[31:16];
            fmt      <= busWdata[15:14];
            level    <= busWdata[13:8];
            rawMode  <= busWdata[7];
            prescale <= busWdata[6:0];
          end
          ADDR_MASK: maskReg <= busWdata[2:0];
          ADDR_ARM:  armed   <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    ctl.run      = enReg && armed && rawMode && (busyCnt == '0);
    ctl.invert   = fmt[0];
    ctl.prescale = prescale;
    ctl.maxWidth = maxWidth;
    ctl.popReq   = busRd && (busAddr == ADDR_DATA) && (fill != '0);
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_ON:     busRdata[0] = enReg;
      ADDR_SETUP:  busRdata = {maxWidth, fmt, level, rawMode, prescale};
      ADDR_BUSY:   busRdata[0] = (busyCnt != '0);
      ADDR_FILL:   busRdata[CNT_W-1:0] = fill;
      ADDR_DATA:   busRdata = (fill != '0) ? head : '0;
      ADDR_MASK:   busRdata[2:0] = maskReg;
      ADDR_STATUS: begin
        busRdata[10:8]  = rawStat;
        busRdata[26:24] = shownStat;
      end
      default: busRdata = '0;
    endcase
  end

endmodule

// File: rtl/ir_symbol_rx.sv
module ir_symbol_rx
  import irrx_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int BUSY_CYCLES = 8,
  parameter int UNIT_DIV = 10,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        irIn,
  output logic        irq
);

  ctrlStrobe_t ctl;
  dpEvent_t evt;
  logic [CNT_W-1:0] fill;
  logic [WORD_W-1:0] head;

  irrx_ctrl #(.CNT_W(CNT_W), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busRd    (busRd),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .evt      (evt),
    .fill     (fill),
    .head     (head),
    .ctl      (ctl),
    .irq      (irq)
  );

  irrx_datapath #(.DEPTH(FIFO_DEPTH), .UNIT_DIV(UNIT_DIV)) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl),
    .irIn (irIn),
    .evt  (evt),
    .fill (fill),
    .head (head)
  );

endmodule

// File: rtl/irrx_checker.sv
module irrx_checker
  import irrx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWr,
  input logic [7:0]       busAddr,
  input logic [31:0]      busWdata,
  input ctrlStrobe_t      ctl,
  input dpEvent_t         evt,
  input logic [CNT_W-1:0] fill
);

  // R5: the count never exceeds the FIFO depth
  a_r5_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    fill <= CNT_W'(DEPTH));

  // R5: a pop request only reaches the FIFO when it holds entries
  a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    ctl.popReq |-> fill != '0);

  // R3: a stored symbol without a pop grows the count by one
  a_r3_store_grows: assert property (@(posedge clk) disable iff (!rstN)
    evt.symDone && !ctl.popReq |=> fill == $past(fill) + {{(CNT_W-1){1'b0}}, 1'b1});

  // R7: a dropped symbol leaves the stored count unchanged
  a_r7_drop_keeps_fill: assert property (@(posedge clk) disable iff (!rstN)
    evt.symDropped && !ctl.popReq |=> fill == $past(fill));

  // R10: nothing completes while capture is not running
  a_r10_idle_no_store: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |-> !evt.symDone && !evt.symDropped && !evt.symTimeout);

  // R2: turning the block on holds capture off on the next cycle
  a_r2_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == ADDR_ON && busWdata[0] |=> !ctl.run);

endmodule

bind ir_symbol_rx irrx_checker #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .ctl      (ctl),
  .evt      (evt),
  .fill     (fill)
);

// File: tb/sim_ir_symbol_rx.sv
module sim_ir_symbol_rx;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int BUSY = 8;
  localparam int MAXW = 30;

  localparam logic [7:0] A_ON = 8'h00, A_SETUP = 8'h04, A_BUSY = 8'h1C, A_FILL = 8'h20;
  localparam logic [7:0] A_DATA = 8'h24, A_MASK = 8'h28, A_STAT = 8'h2C, A_CLR = 8'h30, A_ARM = 8'h34;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irIn = 1'b1;
  logic irq;
  logic invertMode = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_symbol_rx #(.FIFO_DEPTH(DEPTH), .BUSY_CYCLES(BUSY), .UNIT_DIV(10)) u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irIn(irIn), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  // driver: shapes the line and pushes the expected entry
  task automatic sendSymbol(input int p, input int s);
    expQ.push_back({16'(s), 16'(p)});
    @(negedge clk) irIn = invertMode;
    repeat (10*p + 4) @(negedge clk);
    irIn = ~invertMode;
    repeat (10*s) @(negedge clk);
  endtask

  task automatic sendLast(input int p);
    expQ.push_back({16'(MAXW - p), 16'(p)});
    @(negedge clk) irIn = invertMode;
    repeat (10*p + 4) @(negedge clk);
    irIn = ~invertMode;
    repeat (10*(MAXW + 5)) @(negedge clk);
  endtask

  // monitor: reads out every stored entry and compares with the queue
  task automatic drainCompare(input string req);
    logic [31:0] v;
    logic [31:0] e;
    busRead(A_FILL, v);
    check(v == 32'(expQ.size()), {req, " count"}, v, 32'(expQ.size()));
    while (expQ.size() > 0) begin
      e = expQ.pop_front();
      busRead(A_DATA, v);
      check(v == e, {req, " entry"}, v, e);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(A_STAT, v);  check(v == 32'h0, "R1 status", v, 32'h0);
    busRead(A_FILL, v);  check(v == 32'h0, "R1 count", v, 32'h0);
    busRead(A_BUSY, v);  check(v == 32'h0, "R1 busy", v, 32'h0);
    busRead(A_MASK, v);  check(v == 32'h7, "R1 mask", v, 32'h7);
    busRead(A_SETUP, v); check(v == 32'h3E800080, "R1 setup", v, 32'h3E800080);
    check(irq == 1'b0, "R1 irq", 32'(irq), 32'h0);

    // R2 busy after turning on
    busWrite(A_ON, 32'h1);
    busRead(A_BUSY, v); check(v == 32'h1, "R2 busy high", v, 32'h1);
    repeat (BUSY + 4) @(negedge clk);
    busRead(A_BUSY, v); check(v == 32'h0, "R2 busy low", v, 32'h0);

    // setup: width 30 units, level field 2 (three entries), raw on, prescale 0
    busWrite(A_SETUP, {16'(MAXW), 2'b00, 6'd2, 1'b1, 7'd0});
    busWrite(A_MASK, 32'h0);

    // R10 activity before arming stores nothing
    @(negedge clk) irIn = 1'b0;
    repeat (25) @(negedge clk);
    irIn = 1'b1;
    repeat (60) @(negedge clk);
    busRead(A_FILL, v); check(v == 32'h0, "R10 unarmed", v, 32'h0);

    busWrite(A_ARM, 32'h5A);
    repeat (4) @(negedge clk);

    // batch A: two entries, below the level
    sendSymbol(3, 4);
    sendLast(6);
    busRead(A_STAT, v);
    check(v[8] == 1'b0, "R6 below level", 32'(v[8]), 32'h0);
    check(v[9] == 1'b1, "R4 timeout set", 32'(v[9]), 32'h1);
    drainCompare("R3 R4 batch A");
    busRead(A_DATA, v); check(v == 32'h0, "R5 empty read", v, 32'h0);
    busRead(A_FILL, v); check(v == 32'h0, "R5 empty count", v, 32'h0);
    busWrite(A_CLR, 32'h0002_0000);

    // batch B: three entries reach the level
    sendSymbol(2, 6);
    sendSymbol(4, 1);
    sendLast(7);
    busRead(A_STAT, v);
    check(v[10:8] == 3'b011, "R6 level reached", 32'(v[10:8]), 32'h3);
    check(v[26:24] == 3'b011, "R9 shown unmasked", 32'(v[26:24]), 32'h3);
    check(irq == 1'b1, "R9 irq high", 32'(irq), 32'h1);
    drainCompare("R3 R5 batch B");

    // R9 masking
    busWrite(A_MASK, 32'h7);
    busRead(A_STAT, v);
    check(v[26:24] == 3'b000, "R9 masked shown", 32'(v[26:24]), 32'h0);
    check(v[10:8] == 3'b011, "R9 raw kept", 32'(v[10:8]), 32'h3);
    check(irq == 1'b0, "R9 irq masked", 32'(irq), 32'h0);
    busWrite(A_MASK, 32'h6);
    check(irq == 1'b1, "R9 irq one unmasked", 32'(irq), 32'h1);
    busWrite(A_MASK, 32'h0);

    // R8 clears
    busWrite(A_CLR, 32'h0000_FFFF);
    busRead(A_STAT, v); check(v[10:8] == 3'b011, "R8 other bits ignored", 32'(v[10:8]), 32'h3);
    busWrite(A_CLR, 32'h0001_0000);
    busRead(A_STAT, v); check(v[10:8] == 3'b010, "R8 clear received", 32'(v[10:8]), 32'h2);
    busWrite(A_CLR, 32'h0002_0000);
    busRead(A_STAT, v); check(v[10:8] == 3'b000, "R8 clear timeout", 32'(v[10:8]), 32'h0);
    check(irq == 1'b0, "R8 irq after clear", 32'(irq), 32'h0);

    // R11 inverted polarity, level field 0
    busWrite(A_ON, 32'h0);
    invertMode = 1'b1;
    @(negedge clk) irIn = 1'b0;
    busWrite(A_SETUP, {16'(MAXW), 2'b01, 6'd0, 1'b1, 7'd0});
    busWrite(A_ON, 32'h1);
    repeat (BUSY + 4) @(negedge clk);
    busWrite(A_ARM, 32'h0);
    repeat (4) @(negedge clk);
    sendSymbol(2, 3);
    sendLast(5);
    drainCompare("R11 inverted");
    busWrite(A_CLR, 32'h0007_0000);

    // R7 overflow: 65 short symbols plus a final one into 64 entries
    for (int i = 0; i < 65; i++) sendSymbol(1, 1);
    sendLast(1);
    void'(expQ.pop_back());
    void'(expQ.pop_back());
    busRead(A_STAT, v); check(v[10] == 1'b1, "R7 overflow set", 32'(v[10]), 32'h1);
    busRead(A_FILL, v); check(v == 32'(DEPTH), "R7 full count", v, 32'(DEPTH));
    drainCompare("R7 kept entries");
    busRead(A_STAT, v); check(v[10] == 1'b1, "R7 flag held after drain", 32'(v[10]), 32'h1);
    busWrite(A_CLR, 32'h0004_0000);
    busRead(A_STAT, v); check(v[10] == 1'b0, "R8 clear overflow", 32'(v[10]), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule